// File: doc/BRIEF.md
# Windowed Watchdog with Service Key

This block supervises software by counting a time-out period that software must keep restarting. A 3-bit rate field picks one of seven periods, and a zero rate switches supervision off. Software services the watchdog through an 8-bit key register. It first writes 0x55 and later writes 0xAA. Other bus traffic may fall between the two writes. An optional window bit makes the block reject service writes made too early in the period.

A wrong key, an out-of-order key, an early write in window mode, or a period that runs out each raise a single-cycle reset request. The reset request clears the period counter and the key state. The period counter advances on a prescaled tick derived from the clock. Registers are reached through a one-bit address write port and a combinational read port.

Register map: address 0 is the control register. Its bits [2:0] hold the rate and bit 3 is the window enable. Address 1 is the key register.

Top module: `wdg_windowed_watchdog`

## Requirements
- R1: Out of reset no request is raised and the control register reads 0x00. The key register (address 1) always reads 0x00. The control register reads back its low four written bits.
- R2: While the rate is 0, key writes have no effect and no request is ever raised.
- R3: With a nonzero rate, a key write of any value other than 0x55 or 0xAA raises the request in the cycle after the write.
- R4: A 0xAA write that follows a pending 0x55 restarts the period and raises no request. The two writes need not be consecutive.
- R5: Further 0x55 writes while 0x55 is pending raise no request and keep the key pending.
- R6: A 0xAA write with no pending 0x55 raises the request.
- R7: For rate r, the period is P = 2^(BASE_EXP + STEP_EXP·r) ticks. If the period runs out without service, the request appears exactly P ticks after the last restart.
- R8: With the window bit set, a key write taken while the tick count is below P − P/4 raises the request. Key writes at or above that count are judged as in R3 to R6.
- R9: A request clears the tick count and any pending key, so a 0xAA write right after it faults and the next time-out comes P ticks later.
- R10: Any control write restarts the period under the new rate and drops a pending 0x55.
- R11: A valid 0xAA service taken on the same cycle as the expiring tick wins, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 control, 1 key |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 1 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| wdog_rst_o | output | 1 | Single-cycle watchdog reset request |

## Verification
A key-write fault leaves the request register one edge after the edge that captures the write. The bench drives every write on a falling edge and samples on the next falling edge, so each write result is read exactly one edge later. A time-out request appears P edges after the restarting edge, and the bench counts falling edges from that edge to check that the pulse is absent before edge P, present at P and gone one edge later. Read data is combinational and is sampled in the same half cycle in which the address is set. Window cases place the capturing edge at counts P − P/4 − 1 and P − P/4 to test both sides of the boundary.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int unsigned RATE_W = 3;
  localparam int unsigned NUM_RATES = 1 << RATE_W;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_KEY  = 1'b1;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef struct packed {
    logic              win_en;
    logic [RATE_W-1:0] rate;
  } wdg_ctrl_t;

  function automatic int unsigned period_log2(input int unsigned base_exp,
                                              input int unsigned step_exp,
                                              input int unsigned rate);
    return base_exp + step_exp * rate;
  endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);

      logic [PW-1:0] pre_q, pre_d;
      logic          wrap;

      assign wrap = (pre_q == LAST);

      always_comb begin
        pre_d = wrap ? '0 : pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      assign tick_o = wrap;

      p_tick_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/wdg_period_ctr.sv
module wdg_period_ctr
  import wdg_pkg::*;
#(
  parameter int unsigned BASE_EXP = 8,
  parameter int unsigned STEP_EXP = 2,
  localparam int unsigned CW = BASE_EXP + STEP_EXP * (NUM_RATES - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [CW-1:0]     cnt_o,
  output logic              expire_o,
  output logic              win_open_o
);

  logic [CW:0]   len_tab [NUM_RATES];
  logic [CW:0]   len, last, thr;
  logic [CW-1:0] cnt_q, cnt_d;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_len
    assign len_tab[g] = (CW+1)'(1) << period_log2(BASE_EXP, STEP_EXP, g);
  end

  assign len  = len_tab[rate_i];
  assign last = len - 1'b1;
  assign thr  = len - (len >> 2);

  assign expire_o   = en_i && tick_i && ({1'b0, cnt_q} == last);
  assign win_open_o = ({1'b0, cnt_q} >= thr);
  assign cnt_o      = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i || clr_i)  cnt_d = '0;
    else if (expire_o)   cnt_d = '0;
    else if (tick_i)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_off_holds_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));

  p_cnt_below_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> ({1'b0, cnt_q} < len));

endmodule

// File: rtl/wdg_key_seq.sv
module wdg_key_seq
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr_i,
  input  logic [7:0] key_i,
  input  logic       win_en_i,
  input  logic       win_open_i,
  input  logic       clr_i,
  output logic       pending_o,
  output logic       service_o,
  output logic       key_fault_o
);

  logic pend_q, pend_d;
  logic is_first, is_second, in_win, arm_ok;

  assign is_first  = (key_i == KEY_FIRST);
  assign is_second = (key_i == KEY_SECOND);
  assign in_win    = !win_en_i || win_open_i;

  assign arm_ok      = key_wr_i && is_first && in_win;
  assign service_o   = key_wr_i && is_second && pend_q && in_win;
  assign key_fault_o = key_wr_i && !(arm_ok || service_o);
  assign pending_o   = pend_q;

  always_comb begin
    pend_d = pend_q;
    if (clr_i)          pend_d = 1'b0;
    else if (service_o) pend_d = 1'b0;
    else if (arm_ok)    pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  p_pending_from_first_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(key_wr_i && (key_i == KEY_FIRST)));

  p_second_without_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr_i && is_second && !pend_q) |-> key_fault_o);

endmodule

// File: rtl/wdg_windowed_watchdog.sv
module wdg_windowed_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned BASE_EXP = 8,
  parameter int unsigned STEP_EXP = 2,
  parameter int unsigned PRESCALE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic       wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       wdog_rst_o
);

  localparam int unsigned CW = BASE_EXP + STEP_EXP * (NUM_RATES - 1);
  localparam int unsigned CTRL_W = $bits(wdg_ctrl_t);

  wdg_ctrl_t     ctrl_q, ctrl_d;
  logic          ctrl_wr, key_wr, enabled;
  logic          tick, expire, win_open;
  logic [CW-1:0] cnt;
  logic          pending, service, key_fault;
  logic          fault, clr_all;
  logic          req_q, req_d;

  // write decode
  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign enabled = (ctrl_q.rate != '0);
  assign key_wr  = wr_en_i && (wr_addr_i == ADDR_KEY) && enabled;

  // control register
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = wdg_ctrl_t'(wr_data_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // read port: key register always reads zero
  assign rd_data_o = (rd_addr_i == ADDR_KEY) ? 8'h00
                                             : {{(8-CTRL_W){1'b0}}, ctrl_q};

  wdg_prescaler #(
    .DIV (PRESCALE)
  ) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  wdg_period_ctr #(
    .BASE_EXP (BASE_EXP),
    .STEP_EXP (STEP_EXP)
  ) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (enabled),
    .tick_i     (tick),
    .clr_i      (clr_all),
    .rate_i     (ctrl_q.rate),
    .cnt_o      (cnt),
    .expire_o   (expire),
    .win_open_o (win_open)
  );

  wdg_key_seq u_key (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_wr_i    (key_wr),
    .key_i       (wr_data_i),
    .win_en_i    (ctrl_q.win_en),
    .win_open_i  (win_open),
    .clr_i       (clr_all),
    .pending_o   (pending),
    .service_o   (service),
    .key_fault_o (key_fault)
  );

  // fault arbitration: a valid service beats the expiring tick; a control
  // write restarts the period instead of faulting
  assign fault   = !ctrl_wr && (key_fault || (expire && !service));
  assign clr_all = fault || service || ctrl_wr;

  always_comb begin
    req_d = fault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign wdog_rst_o = req_q;

  p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (wr_addr_i == ADDR_KEY) && (ctrl_q.rate != '0) &&
     (wr_data_i != KEY_FIRST) && (wr_data_i != KEY_SECOND)) |=> wdog_rst_o);

  p_window_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && ctrl_q.win_en && !win_open) |=> wdog_rst_o);

  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.rate == '0) |=> !wdog_rst_o);

  p_clear_after_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |-> ((cnt == '0) && !pending));

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    service |=> ((cnt == '0) && !pending && !wdog_rst_o));

  p_ctrl_fresh_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ((cnt == '0) && !pending && !wdog_rst_o));

  p_service_beats_expiry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && service) |=> !wdog_rst_o);

endmodule

// File: tb/wdg_windowed_watchdog_tb_top.sv
module wdg_windowed_watchdog_tb_top;

  // small periods: rate1 -> 8 ticks, rate2 -> 16 ticks, one tick per clock
  localparam int unsigned BASE_EXP = 2;
  localparam int unsigned STEP_EXP = 1;
  localparam int unsigned PRESCALE = 1;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic       wr_addr;
  logic [7:0] wr_data;
  logic       rd_addr;
  logic [7:0] rd_data;
  logic       wdog_rst;

  int n_checks = 0;
  int n_fail   = 0;

  wdg_windowed_watchdog #(
    .BASE_EXP (BASE_EXP),
    .STEP_EXP (STEP_EXP),
    .PRESCALE (PRESCALE)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .wdog_rst_o (wdog_rst)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic       addr;
    logic [7:0] data;
    logic [3:0] gap;
    logic       exp_req;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h01, 4'd0, 1'b0, 4'd10}, // R10 rate1, no window
    '{1'b1, 8'h55, 4'd0, 1'b0, 4'd4},  // R4 first key
    '{1'b1, 8'hAA, 4'd2, 1'b0, 4'd4},  // R4 second key after idle cycles
    '{1'b1, 8'h55, 4'd0, 1'b0, 4'd5},  // R5
    '{1'b1, 8'h55, 4'd1, 1'b0, 4'd5},  // R5 repeated first key
    '{1'b1, 8'h55, 4'd0, 1'b0, 4'd5},  // R5
    '{1'b1, 8'hAA, 4'd0, 1'b0, 4'd4},  // R4 restart
    '{1'b1, 8'h3C, 4'd0, 1'b1, 4'd3},  // R3 wrong key
    '{1'b1, 8'hAA, 4'd0, 1'b1, 4'd6},  // R6 second key alone
    '{1'b1, 8'h00, 4'd0, 1'b1, 4'd3},  // R3 zero key
    '{1'b1, 8'h55, 4'd0, 1'b0, 4'd4},  // R4
    '{1'b0, 8'h01, 4'd0, 1'b0, 4'd10}, // R10 control write drops pending
    '{1'b1, 8'hAA, 4'd0, 1'b1, 4'd10}, // R10 so this faults
    '{1'b0, 8'h00, 4'd0, 1'b0, 4'd2},  // R2 disable
    '{1'b1, 8'h3C, 4'd0, 1'b0, 4'd2},  // R2 ignored
    '{1'b1, 8'hAA, 4'd3, 1'b0, 4'd2},  // R2 ignored
    '{1'b0, 8'h09, 4'd0, 1'b0, 4'd8},  // R8 rate1 with window (opens at 6)
    '{1'b1, 8'h55, 4'd5, 1'b1, 4'd8},  // R8 count 5: early
    '{1'b1, 8'h55, 4'd6, 1'b0, 4'd8},  // R8 count 6: inside
    '{1'b1, 8'hAA, 4'd0, 1'b0, 4'd11}, // R11 count 7 with expiry
    '{1'b1, 8'h55, 4'd6, 1'b0, 4'd8},  // R8
    '{1'b1, 8'h55, 4'd0, 1'b1, 4'd7},  // R7 first key on expiry: time-out
    '{1'b1, 8'hAA, 4'd0, 1'b1, 4'd9}   // R9 pending cleared by fault
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns the request seen one edge later
  task automatic do_write(input logic a, input logic [7:0] d, output logic got);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = 8'h00;
    got     = wdog_rst;
  endtask

  task automatic idle_quiet(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk({7'd0, wdog_rst}, 8'd0, tag);
    end
  endtask

  // pulse due at the n-th falling edge after the restarting edge, then gone
  task automatic expect_timeout(input int n, input string tag);
    for (int k = 1; k <= n + 1; k++) begin
      @(negedge clk);
      chk({7'd0, wdog_rst}, {7'd0, (k == n)}, tag);
    end
  endtask

  initial begin
    logic got;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = 1'b0;
    wr_data = 8'h00;
    rd_addr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk({7'd0, wdog_rst}, 8'd0, "R1 no request after reset");
    rd_addr = 1'b0; #0.5;
    chk(rd_data, 8'h00, "R1 control reset value");
    rd_addr = 1'b1; #0.5;
    chk(rd_data, 8'h00, "R1 key register reads zero");

    // vector table
    for (int i = 0; i < NV; i++) begin
      for (int g = 0; g < VECS[i].gap; g++) begin
        @(negedge clk);
        chk({7'd0, wdog_rst}, 8'd0, $sformatf("R%0d idle before vector %0d", VECS[i].req, i));
      end
      do_write(VECS[i].addr, VECS[i].data, got);
      chk({7'd0, got}, {7'd0, VECS[i].exp_req},
          $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R1 readback after writes
    rd_addr = 1'b1; #0.5;
    chk(rd_data, 8'h00, "R1 key register still reads zero");
    rd_addr = 1'b0; #0.5;
    chk(rd_data, 8'h09, "R1 control readback");

    // R7 time-out, then R9 next time-out a full period after the request
    do_write(1'b0, 8'h01, got);
    expect_timeout(8, "R7 rate1 time-out");
    expect_timeout(7, "R9 period restarts at request");

    // R10 rate change mid-period starts a fresh, longer period
    do_write(1'b0, 8'h01, got);
    idle_quiet(5, "R10 before rate change");
    do_write(1'b0, 8'h02, got);
    expect_timeout(16, "R10 rate2 time-out after change");

    // R2 disabled: nothing ever fires
    do_write(1'b0, 8'h00, got);
    do_write(1'b1, 8'h12, got);
    chk({7'd0, got}, 8'd0, "R2 bad key ignored when off");
    idle_quiet(40, "R2 no time-out when off");

    // R8 window boundary at rate2 (P=16, opens at 12)
    do_write(1'b0, 8'h0A, got);
    repeat (11) @(negedge clk);
    do_write(1'b1, 8'h55, got);
    chk({7'd0, got}, 8'd1, "R8 rate2 count 11 early");
    repeat (12) @(negedge clk);
    do_write(1'b1, 8'h55, got);
    chk({7'd0, got}, 8'd0, "R8 rate2 count 12 accepted");
    do_write(1'b1, 8'hAA, got);
    chk({7'd0, got}, 8'd0, "R4 window service restarts");
    expect_timeout(16, "R4 full period after windowed service");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: bench hung, actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule